// File: doc/BRIEF.md
# Address/Data Track-Mode Bridge

This block lets an 8-bit peripheral port follow a host's multiplexed address/data bus, so that a second processor or a shared resource on the far side sees the host's bus cycles. The one port changes direction up to three times in a bus cycle. While the address strobe is high it carries the address outward. During a read it carries data inward from the port to the host bus. During a write it carries host data outward. Three decode enables, produced elsewhere, select which of these transfers are allowed. The chip-select logic that produces them is not part of this block.

All inputs are sampled on the block clock and every output is registered, so each output reflects the inputs of the previous clock edge. After a write, the port keeps driving the last write data for a programmable number of cycles, which gives the far side a hold window. A selector input chooses one of two host control styles. In the first, the host has separate active-low read and write strobes. In the second, it has a read/write level and an active-high data strobe.

Top module: `ad_track_bridge`

## Requirements
- R1: When the address strobe and the address-out enable are both high at a clock edge, after that edge the port output enable is 1 and the port value equals the host AD value sampled at that edge.
- R2: When the address strobe is high and the address-out enable is low at an edge, after that edge neither the port nor the host bus is driven, and any write hold in progress ends.
- R3: At the first edge after the address strobe falls, if no enabled data transfer is active, the port output enable drops to 0.
- R4: With the strobe low, an active read and the data-in enable high, the host output enable is 1 after the edge and the host value equals the port input sampled at that edge. The port is not driven.
- R5: With the strobe low, an active write, no active enabled read and the data-out enable high, the port output enable is 1 and the port value tracks the host AD value sampled at each edge.
- R6: When a write transfer ends, the port keeps its output enable at 1 and holds the last write value for HOLD_CYC cycles (default 2), then releases. A strobe or an enabled read ends the hold at once.
- R7: The port output enable and the host output enable are never 1 together. If both data enables are high, the read transfer is used on a read and the write transfer is used on a write. With no read or write active, nothing is driven.
- R8: With style select 0, ctl_a is the read strobe and ctl_b is the write strobe, both active low. With style select 1, ctl_a is the read/write level (1 = read) and ctl_b is the data strobe, active high.
- R9: While reset is low, both output enables and both output values are 0.
- R10: A read or write without its matching enable, or a cycle with no enable high, leaves the port undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| bus_style_i | input | 1 | Control style select (see R8) |
| host_ad_i | input | 8 | Host multiplexed address/data bus, as sampled |
| host_as_i | input | 1 | Address strobe, active high |
| host_ctl_a_i | input | 1 | Control line A: read strobe or read/write level |
| host_ctl_b_i | input | 1 | Control line B: write strobe or data strobe |
| en_addr_i | input | 1 | Address-out enable |
| en_din_i | input | 1 | Data-in (port to host) enable |
| en_dout_i | input | 1 | Data-out (host to port) enable |
| port_i | input | 8 | Value read from the peripheral port pins |
| port_o | output | 8 | Value driven onto the peripheral port |
| port_oe_o | output | 1 | Port output enable |
| host_o | output | 8 | Value driven onto the host AD bus |
| host_oe_o | output | 1 | Host AD output enable |

## Verification
The bench raises both data enables on a read and on a write. A design with the wrong priority would drive both sides at once, or would leave the port driving into the host during a read. The bench counts the exact number of hold cycles after a write and checks that a strobe with the address enable low, or a new read, cuts the hold short. An off-by-one counter, or a hold that ignores a new cycle, shows up as a wrong port enable in a specific cycle. The same transfers are repeated in the second control style, and a reset is applied in the middle of a cycle. These catch a swapped or wrongly polarised strobe decode and registers that survive reset.

// File: rtl/trk_pkg.sv
package trk_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_ADDR  = 3'd1,
        PH_READ  = 3'd2,
        PH_WRITE = 3'd3,
        PH_HOLD  = 3'd4
    } phase_e;

    function automatic int unsigned cnt_width(input int unsigned limit);
        int unsigned w;
        w = 1;
        while ((1 << w) <= limit) w++;
        return w;
    endfunction

endpackage

// File: rtl/trk_ctl_decode.sv
module trk_ctl_decode (
    input  logic style_i,
    input  logic ctl_a_i,
    input  logic ctl_b_i,
    output logic rd_o,
    output logic wr_o
);

    logic rd_sep, wr_sep;
    logic rd_lvl, wr_lvl;

    // style 0: separate active-low strobes
    always_comb begin
        rd_sep = ~ctl_a_i;
        wr_sep = ~ctl_b_i;
    end

    // style 1: direction level plus active-high data strobe
    always_comb begin
        rd_lvl = ctl_b_i & ctl_a_i;
        wr_lvl = ctl_b_i & ~ctl_a_i;
    end

    always_comb begin
        rd_o = style_i ? rd_lvl : rd_sep;
        wr_o = style_i ? wr_lvl : wr_sep;
    end

    // R8: in the level style a single cycle is never both read and write
    always_comb begin
        if (style_i === 1'b1) begin
            a_r8_level_exclusive: assert (!(rd_o && wr_o));
        end
    end

endmodule

// File: rtl/trk_phase.sv
module trk_phase
    import trk_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 2
) (
    input  logic   clk_i,
    input  logic   rst_n_i,
    input  logic   as_i,
    input  logic   rd_i,
    input  logic   wr_i,
    input  logic   en_addr_i,
    input  logic   en_din_i,
    input  logic   en_dout_i,
    output phase_e phase_nx_o
);

    localparam int unsigned CNT_W = cnt_width(HOLD_CYC);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
    } ph_state_t;

    ph_state_t st_d, st_q;
    logic      hold_live;

    always_comb begin
        st_d      = st_q;
        hold_live = ((st_q.phase == PH_WRITE) || (st_q.phase == PH_HOLD))
                    && (st_q.cnt != '0);
        if (as_i) begin
            st_d.phase = en_addr_i ? PH_ADDR : PH_IDLE;
            st_d.cnt   = '0;
        end else if (rd_i && en_din_i) begin
            st_d.phase = PH_READ;
            st_d.cnt   = '0;
        end else if (wr_i && en_dout_i) begin
            st_d.phase = PH_WRITE;
            st_d.cnt   = CNT_W'(HOLD_CYC);
        end else if (hold_live) begin
            st_d.phase = PH_HOLD;
            st_d.cnt   = st_q.cnt - 1'b1;
        end else begin
            st_d.phase = PH_IDLE;
            st_d.cnt   = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            st_q <= '{phase: PH_IDLE, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_nx_o = st_d.phase;

    // R6: the hold never runs longer than HOLD_CYC cycles
    a_r6_hold_bounded: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (st_q.phase == PH_HOLD) |-> (st_q.cnt < CNT_W'(HOLD_CYC)));

    // R7: an enabled read outranks an enabled write
    a_r7_read_wins: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ($past(rst_n_i) && $past(!as_i && rd_i && en_din_i)) |-> (st_q.phase == PH_READ));

    // R2: a strobe without address enable cancels any hold
    a_r2_strobe_cancels: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ($past(rst_n_i) && $past(as_i && !en_addr_i)) |-> (st_q.phase == PH_IDLE));

endmodule

// File: rtl/trk_drive.sv
module trk_drive
    import trk_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  phase_e            phase_nx_i,
    input  logic [DATA_W-1:0] host_ad_i,
    input  logic [DATA_W-1:0] port_i,
    output logic [DATA_W-1:0] port_o,
    output logic              port_oe_o,
    output logic [DATA_W-1:0] host_o,
    output logic              host_oe_o
);

    typedef struct packed {
        logic [DATA_W-1:0] port_val;
        logic              port_oe;
        logic [DATA_W-1:0] host_val;
        logic              host_oe;
    } drv_t;

    drv_t drv_d, drv_q;

    always_comb begin
        drv_d         = drv_q;
        drv_d.port_oe = 1'b0;
        drv_d.host_oe = 1'b0;
        unique case (phase_nx_i)
            PH_ADDR, PH_WRITE: begin
                drv_d.port_val = host_ad_i;
                drv_d.port_oe  = 1'b1;
            end
            PH_HOLD: begin
                drv_d.port_oe  = 1'b1;
            end
            PH_READ: begin
                drv_d.host_val = port_i;
                drv_d.host_oe  = 1'b1;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            drv_q <= '0;
        end else begin
            drv_q <= drv_d;
        end
    end

    assign port_o    = drv_q.port_val;
    assign port_oe_o = drv_q.port_oe;
    assign host_o    = drv_q.host_val;
    assign host_oe_o = drv_q.host_oe;

    // R7: the two sides are never driven together
    a_r7_no_contention: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !(port_oe_o && host_oe_o));

    // R6: during the hold the port value stays frozen
    a_r6_hold_value: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ($past(rst_n_i) && $past(phase_nx_i == PH_HOLD))
        |-> (port_oe_o && port_o == $past(port_o)));

endmodule

// File: rtl/ad_track_bridge.sv
module ad_track_bridge
    import trk_pkg::*;
#(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned HOLD_CYC = 2
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              bus_style_i,
    input  logic [DATA_W-1:0] host_ad_i,
    input  logic              host_as_i,
    input  logic              host_ctl_a_i,
    input  logic              host_ctl_b_i,
    input  logic              en_addr_i,
    input  logic              en_din_i,
    input  logic              en_dout_i,
    input  logic [DATA_W-1:0] port_i,
    output logic [DATA_W-1:0] port_o,
    output logic              port_oe_o,
    output logic [DATA_W-1:0] host_o,
    output logic              host_oe_o
);

    logic   rd, wr;
    phase_e phase_nx;

    trk_ctl_decode i_decode (
        .style_i (bus_style_i),
        .ctl_a_i (host_ctl_a_i),
        .ctl_b_i (host_ctl_b_i),
        .rd_o    (rd),
        .wr_o    (wr)
    );

    trk_phase #(.HOLD_CYC(HOLD_CYC)) i_phase (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .as_i       (host_as_i),
        .rd_i       (rd),
        .wr_i       (wr),
        .en_addr_i  (en_addr_i),
        .en_din_i   (en_din_i),
        .en_dout_i  (en_dout_i),
        .phase_nx_o (phase_nx)
    );

    trk_drive #(.DATA_W(DATA_W)) i_drive (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .phase_nx_i (phase_nx),
        .host_ad_i  (host_ad_i),
        .port_i     (port_i),
        .port_o     (port_o),
        .port_oe_o  (port_oe_o),
        .host_o     (host_o),
        .host_oe_o  (host_oe_o)
    );

    // R1: address forwarded one edge later
    a_r1_addr_follow: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ($past(rst_n_i) && $past(host_as_i && en_addr_i))
        |-> (port_oe_o && !host_oe_o && port_o == $past(host_ad_i)));

    // R4: read data forwarded to the host bus
    a_r4_read_path: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ($past(rst_n_i) && $past(!host_as_i && rd && en_din_i))
        |-> (host_oe_o && !port_oe_o && host_o == $past(port_i)));

    // R5: write data forwarded to the port
    a_r5_write_path: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ($past(rst_n_i) && $past(!host_as_i && wr && en_dout_i && !(rd && en_din_i)))
        |-> (port_oe_o && !host_oe_o && port_o == $past(host_ad_i)));

    // R10: no enable at all leaves the host side undriven
    a_r10_no_enable: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ($past(rst_n_i) && $past(!en_addr_i && !en_din_i && !en_dout_i))
        |-> !host_oe_o);

endmodule

// File: tb/test_ad_track_bridge.sv
module test_ad_track_bridge;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sty, as_s, ca, cb, ea, ei, eo;
    logic [7:0] ad, pa;
    logic [7:0] port_o, host_o;
    logic       port_oe, host_oe;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2ns clk = ~clk;

    ad_track_bridge i_ad_track_bridge (
        .clk_i        (clk),
        .rst_n_i      (rst_n),
        .bus_style_i  (sty),
        .host_ad_i    (ad),
        .host_as_i    (as_s),
        .host_ctl_a_i (ca),
        .host_ctl_b_i (cb),
        .en_addr_i    (ea),
        .en_din_i     (ei),
        .en_dout_i    (eo),
        .port_i       (pa),
        .port_o       (port_o),
        .port_oe_o    (port_oe),
        .host_o       (host_o),
        .host_oe_o    (host_oe)
    );

    typedef struct packed {
        logic       sty, as_s, ca, cb, ea, ei, eo;
        logic [7:0] ad, pa;
        logic       xpoe;
        logic [7:0] xpv;
        logic       xhoe;
        logic [7:0] xhv;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 22;
    // fields: sty as ca cb ea ei eo ad pa | xpoe xpv xhoe xhv | req
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,8'hA5,8'h00, 1'b1,8'hA5,1'b0,8'h00, 8'd1},  // R1
        '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,8'hA5,8'h00, 1'b0,8'h00,1'b0,8'h00, 8'd3},  // R3
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,8'h00,8'h3C, 1'b0,8'h00,1'b1,8'h3C, 8'd4},  // R4
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,8'h00,8'hC3, 1'b0,8'h00,1'b1,8'hC3, 8'd4},  // R4
        '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'h00,8'h00, 1'b0,8'h00,1'b0,8'h00, 8'd10}, // R10
        '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,8'h12,8'h00, 1'b1,8'h12,1'b0,8'h00, 8'd1},  // R1
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,8'h77,8'h00, 1'b1,8'h77,1'b0,8'h00, 8'd5},  // R5
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,8'h78,8'h00, 1'b1,8'h78,1'b0,8'h00, 8'd5},  // R5
        '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'hFF,8'h00, 1'b1,8'h78,1'b0,8'h00, 8'd6},  // R6
        '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'hEE,8'h00, 1'b1,8'h78,1'b0,8'h00, 8'd6},  // R6
        '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'hDD,8'h00, 1'b0,8'h00,1'b0,8'h00, 8'd6},  // R6
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,8'h00,8'h5A, 1'b0,8'h00,1'b1,8'h5A, 8'd7},  // R7
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,8'h66,8'h00, 1'b1,8'h66,1'b0,8'h00, 8'd7},  // R7
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,8'h00,8'h11, 1'b0,8'h00,1'b1,8'h11, 8'd6},  // R6
        '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,8'h00,8'h22, 1'b0,8'h00,1'b0,8'h00, 8'd7},  // R7
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,8'h21,8'h00, 1'b1,8'h21,1'b0,8'h00, 8'd8},  // R8
        '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,8'h00,8'h9E, 1'b0,8'h00,1'b1,8'h9E, 8'd8},  // R8
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,8'h4B,8'h00, 1'b1,8'h4B,1'b0,8'h00, 8'd8},  // R8
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,8'h30,8'h00, 1'b0,8'h00,1'b0,8'h00, 8'd2},  // R2
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,8'h31,8'h00, 1'b0,8'h00,1'b0,8'h00, 8'd8},  // R8
        '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,8'h32,8'h44, 1'b0,8'h00,1'b0,8'h00, 8'd10}, // R10
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,8'h33,8'h00, 1'b0,8'h00,1'b0,8'h00, 8'd10}  // R10
    };

    task automatic check(input int req, input logic xpoe, input logic [7:0] xpv,
                         input logic xhoe, input logic [7:0] xhv);
        bit bad;
        n_run++;
        bad = (port_oe !== xpoe) || (host_oe !== xhoe)
              || (xpoe && port_o !== xpv) || (xhoe && host_o !== xhv);
        if (bad) begin
            n_fail++;
            $display("FAIL R%0d: got poe=%b pv=%h hoe=%b hv=%h, exp poe=%b pv=%h hoe=%b hv=%h",
                     req, port_oe, port_o, host_oe, host_o, xpoe, xpv, xhoe, xhv);
        end
    endtask

    task automatic idle_inputs();
        sty = 1'b0; as_s = 1'b0; ca = 1'b1; cb = 1'b1;
        ea = 1'b0; ei = 1'b0; eo = 1'b0; ad = 8'h00; pa = 8'h00;
    endtask

    initial begin
        rst_n = 1'b0;
        idle_inputs();
        repeat (3) @(negedge clk);
        // R9: reset state
        check(9, 1'b0, 8'h00, 1'b0, 8'h00);
        if (port_o !== 8'h00 || host_o !== 8'h00) begin
            n_fail++;
            $display("FAIL R9: got pv=%h hv=%h, exp pv=00 hv=00", port_o, host_o);
        end
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            sty = VECS[i].sty; as_s = VECS[i].as_s; ca = VECS[i].ca; cb = VECS[i].cb;
            ea = VECS[i].ea; ei = VECS[i].ei; eo = VECS[i].eo;
            ad = VECS[i].ad; pa = VECS[i].pa;
            @(negedge clk);
            check(int'(VECS[i].req), VECS[i].xpoe, VECS[i].xpv, VECS[i].xhoe, VECS[i].xhv);
        end

        // R9: reset in the middle of an address phase
        idle_inputs();
        as_s = 1'b1; ea = 1'b1; ad = 8'h99;
        @(negedge clk);
        check(1, 1'b1, 8'h99, 1'b0, 8'h00);
        rst_n = 1'b0;
        #1ns;
        check(9, 1'b0, 8'h00, 1'b0, 8'h00);
        if (port_o !== 8'h00) begin
            n_fail++;
            $display("FAIL R9: got pv=%h, exp pv=00", port_o);
        end
        @(negedge clk);
        rst_n = 1'b1;
        idle_inputs();
        @(negedge clk);
        check(10, 1'b0, 8'h00, 1'b0, 8'h00);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #100us;
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got no end, exp end of run");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule